// File: doc/BRIEF.md
# Bus Slave Cycle Decoder

This block is the slave-side front end for an asynchronous, command-strobed expansion bus. It samples the address, the memory/IO flag, the two active-low status lines, the flag that marks an address inside the lowest 16 MB and the active-low high-byte enable. It holds them in a capture register. It classifies the held cycle, compares the held address against one memory window and one IO window, and drives the card-select feedback, a 16-bit port indication and a ready line. The ready line holds a fixed number of wait clocks at the start of every command that selects the card.

On the local side, the block gives a small register file its word address, a read enable, a single-clock write strobe and two byte-lane selects. All bus inputs are assumed to be synchronous to `clk` already. The active-low reset is applied asynchronously and released through a two-stage synchronizer.

Top module: `slave_cycle_decoder`

## Requirements
- R1: The cycle code {bus_mio, bus_s0_n, bus_s1_n} decodes as 001 = IO write, 010 = IO read, 101 = memory write and 110 = memory read. The codes 000, 011, 100 and 111 never select the card.
- R2: An IO cycle selects when bus_addr[15:IO_WIN_BITS] equals IO_BASE[15:IO_WIN_BITS] (default 0x0300 to 0x0307). bus_addr[23:16] and bus_below16m have no effect on an IO cycle.
- R3: A memory cycle selects only when bus_below16m is 1 and bus_addr[23:MEM_WIN_BITS] equals MEM_BASE[23:MEM_WIN_BITS] (default 0x0C8000 to 0x0CBFFF). With bus_below16m at 0 it never selects.
- R4: The capture register loads the bus at every clock edge where bus_adl_n is low, and at the first clock edge of a command (bus_cmd_n newly low). At all other edges it holds, so later changes on the bus do not alter card_sel_n or rf_addr.
- R5: card_sel_n is low exactly while the held cycle decodes to a valid type in its window and bus_setup_n is high. A low bus_setup_n forces card_sel_n high.
- R6: card_ds16_n is low while the live (not held) bus_mio, bus_addr and bus_below16m hit either window, whatever the status lines or capture register hold.
- R7: card_rdy is high unless the card is selected and the command has been active for fewer than WAIT_CLKS clock edges. It is low for exactly WAIT_CLKS (default 2) clocks after the first command edge.
- R8: For a selected write, rf_wr is high for exactly one clock, in the first clock where card_rdy is high during the command. It never rises for reads or for unselected cycles.
- R9: For a selected read, rf_rd is high from the first command edge until the clock edge after bus_cmd_n returns high.
- R10: With the card selected, {bus_bhe_n, held addr[0]} = 00 enables both lanes, 01 only rf_lane_hi, 10 only rf_lane_lo and 11 neither. Both lanes are low when the card is not selected.
- R11: During reset card_sel_n and card_rdy are high, and rf_rd, rf_wr and both lanes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 24 | Bus address |
| bus_mio | input | 1 | 1 = memory cycle, 0 = IO cycle |
| bus_s0_n | input | 1 | Status line 0, active low |
| bus_s1_n | input | 1 | Status line 1, active low |
| bus_below16m | input | 1 | 1 = memory address lies within the lowest 16 MB |
| bus_bhe_n | input | 1 | High-byte enable, active low |
| bus_adl_n | input | 1 | Address latch strobe, active low |
| bus_cmd_n | input | 1 | Command strobe, active low |
| bus_setup_n | input | 1 | Configuration-setup select for this slot, active low |
| card_sel_n | output | 1 | Card-selected feedback, active low |
| card_ds16_n | output | 1 | 16-bit port indication, active low |
| card_rdy | output | 1 | 1 = ready, 0 = insert wait |
| rf_addr | output | REG_AW | Register-file word address from held address |
| rf_rd | output | 1 | Register-file read enable |
| rf_wr | output | 1 | Register-file write strobe, one clock |
| rf_lane_lo | output | 1 | Low byte lane select |
| rf_lane_hi | output | 1 | High byte lane select |

## Verification
The bench runs the reserved cycle codes at addresses that do hit a window. A decoder that ignored one status line would answer them. It runs IO addresses with garbage in the upper byte and memory addresses with the 16 MB flag cleared, which catch a window compare that uses too many or too few bits. It starts one command with no address strobe, then moves the address mid-command. A capture that stays transparent, or misses the command edge, shows up as a wrong rf_addr or a dropped select. The ready and write-strobe timing is checked clock by clock, so a wait count that is off by one, or a strobe that fires during the wait or repeats, is seen directly.

// File: rtl/slv_dec_pkg.sv
package slv_dec_pkg;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_IO_RD  = 3'd1,
    CYC_IO_WR  = 3'd2,
    CYC_MEM_RD = 3'd3,
    CYC_MEM_WR = 3'd4
  } cyc_t;

  typedef struct packed {
    logic [23:0] addr;
    logic        mio;
    logic        s0_n;
    logic        s1_n;
    logic        below16m;
    logic        bhe_n;
  } bus_phase_t;

  localparam bus_phase_t PHASE_IDLE = '{addr: 24'h0, mio: 1'b0, s0_n: 1'b1,
                                        s1_n: 1'b1, below16m: 1'b0, bhe_n: 1'b1};

  function automatic cyc_t classify(input bus_phase_t p);
    case ({p.mio, p.s0_n, p.s1_n})
      3'b001:  classify = CYC_IO_WR;
      3'b010:  classify = CYC_IO_RD;
      3'b101:  classify = CYC_MEM_WR;
      3'b110:  classify = CYC_MEM_RD;
      default: classify = CYC_NONE;
    endcase
  endfunction

  function automatic logic is_read(input cyc_t c);
    is_read = (c == CYC_IO_RD) || (c == CYC_MEM_RD);
  endfunction

  function automatic logic is_write(input cyc_t c);
    is_write = (c == CYC_IO_WR) || (c == CYC_MEM_WR);
  endfunction

endpackage

// File: rtl/slv_dec_capture.sv
module slv_dec_capture
  import slv_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  bus_phase_t d,
  output bus_phase_t q
);

  bus_phase_t q_r;
  bus_phase_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (cap) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= PHASE_IDLE;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/slv_dec_window.sv
module slv_dec_window
  import slv_dec_pkg::*;
#(
  parameter logic [15:0] IO_BASE      = 16'h0300,
  parameter int          IO_WIN_BITS  = 3,
  parameter logic [23:0] MEM_BASE     = 24'h0C8000,
  parameter int          MEM_WIN_BITS = 14
) (
  input  bus_phase_t p,
  output logic       hit
);

  logic io_hit;
  logic mem_hit;

  always_comb begin
    io_hit  = !p.mio && ((p.addr[15:0] >> IO_WIN_BITS) == (IO_BASE >> IO_WIN_BITS));
    mem_hit = p.mio && p.below16m &&
              ((p.addr >> MEM_WIN_BITS) == (MEM_BASE >> MEM_WIN_BITS));
    hit     = io_hit || mem_hit;
  end

endmodule

// File: rtl/slv_dec_wait.sv
module slv_dec_wait #(
  parameter int WAIT_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_act,
  input  logic cmd_lead,
  output logic busy
);

  localparam int WCW = (WAIT_CLKS > 0) ? $clog2(WAIT_CLKS + 1) : 1;
  localparam logic [WCW-1:0] WLOAD = WCW'(WAIT_CLKS);

  logic [WCW-1:0] cnt_r;
  logic [WCW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_r;
    if (!cmd_act)          cnt_nxt = '0;
    else if (cmd_lead)     cnt_nxt = WLOAD;
    else if (cnt_r != '0)  cnt_nxt = cnt_r - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_nxt;
  end

  assign busy = (cnt_r != '0);

endmodule

// File: rtl/slave_cycle_decoder.sv
module slave_cycle_decoder
  import slv_dec_pkg::*;
#(
  parameter logic [15:0] IO_BASE      = 16'h0300,
  parameter int          IO_WIN_BITS  = 3,
  parameter logic [23:0] MEM_BASE     = 24'h0C8000,
  parameter int          MEM_WIN_BITS = 14,
  parameter int          WAIT_CLKS    = 2,
  parameter int          REG_AW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       bus_addr,
  input  logic              bus_mio,
  input  logic              bus_s0_n,
  input  logic              bus_s1_n,
  input  logic              bus_below16m,
  input  logic              bus_bhe_n,
  input  logic              bus_adl_n,
  input  logic              bus_cmd_n,
  input  logic              bus_setup_n,
  output logic              card_sel_n,
  output logic              card_ds16_n,
  output logic              card_rdy,
  output logic [REG_AW-1:0] rf_addr,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic              rf_lane_lo,
  output logic              rf_lane_hi
);

  localparam int NDEC = 2;  // 0: live bus, 1: held phase

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // command edge tracking
  logic cmd_act, cmd_seen, cmd_seen_nxt, cmd_lead;

  assign cmd_act      = !bus_cmd_n;
  assign cmd_lead     = cmd_act && !cmd_seen;
  assign cmd_seen_nxt = cmd_act;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cmd_seen <= 1'b0;
    else             cmd_seen <= cmd_seen_nxt;
  end

  // capture of the address phase
  bus_phase_t live_ph, held_ph;
  logic       cap_en;

  assign live_ph = '{addr: bus_addr, mio: bus_mio, s0_n: bus_s0_n, s1_n: bus_s1_n,
                     below16m: bus_below16m, bhe_n: bus_bhe_n};
  assign cap_en  = !bus_adl_n || cmd_lead;

  slv_dec_capture u_cap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cap   (cap_en),
    .d     (live_ph),
    .q     (held_ph)
  );

  // window compare, one copy on the live bus and one on the held phase
  bus_phase_t      dec_in [NDEC];
  logic [NDEC-1:0] dec_hit;

  assign dec_in[0] = live_ph;
  assign dec_in[1] = held_ph;

  for (genvar g = 0; g < NDEC; g++) begin : g_win
    slv_dec_window #(
      .IO_BASE      (IO_BASE),
      .IO_WIN_BITS  (IO_WIN_BITS),
      .MEM_BASE     (MEM_BASE),
      .MEM_WIN_BITS (MEM_WIN_BITS)
    ) u_win (
      .p   (dec_in[g]),
      .hit (dec_hit[g])
    );
  end

  // cycle classification and select
  cyc_t cyc;
  logic sel;

  assign cyc = classify(held_ph);
  assign sel = (cyc != CYC_NONE) && dec_hit[1] && bus_setup_n;

  // wait-state timer
  logic busy;

  slv_dec_wait #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_act  (cmd_act),
    .cmd_lead (cmd_lead),
    .busy     (busy)
  );

  // write strobe bookkeeping for one pulse per command
  logic wr_done, wr_done_nxt, wr_pulse;

  assign wr_pulse    = sel && is_write(cyc) && cmd_act && cmd_seen && !busy && !wr_done;
  assign wr_done_nxt = cmd_act ? (wr_done || wr_pulse) : 1'b0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_done <= 1'b0;
    else             wr_done <= wr_done_nxt;
  end

  // outputs
  assign card_sel_n  = !sel;
  assign card_ds16_n = !dec_hit[0];
  assign card_rdy    = !(sel && busy);
  assign rf_addr     = held_ph.addr[REG_AW-1:0];
  assign rf_rd       = sel && is_read(cyc) && (cmd_act || cmd_seen);
  assign rf_wr       = wr_pulse;
  assign rf_lane_lo  = sel && !held_ph.addr[0];
  assign rf_lane_hi  = sel && !held_ph.bhe_n;

endmodule

// File: rtl/slv_dec_chk.sv
module slv_dec_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_cmd_n,
  input logic bus_setup_n,
  input logic card_sel_n,
  input logic card_rdy,
  input logic rf_rd,
  input logic rf_wr,
  input logic rf_lane_lo,
  input logic rf_lane_hi
);

  AST_SETUP_MUTES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_setup_n |-> card_sel_n);                                     // R5

  AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr);                                                 // R8

  AST_WR_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> card_rdy);                                               // R7

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_rd && rf_wr));                                                // R9

  AST_RDY_FALL_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_rdy) |-> !$past(bus_cmd_n));                            // R7

  AST_RDY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_n && $past(bus_cmd_n)) |-> card_rdy);                     // R7

  AST_LANE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_lane_lo || rf_lane_hi) |-> !card_sel_n);                       // R10

endmodule

bind slave_cycle_decoder slv_dec_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_cmd_n   (bus_cmd_n),
  .bus_setup_n (bus_setup_n),
  .card_sel_n  (card_sel_n),
  .card_rdy    (card_rdy),
  .rf_rd       (rf_rd),
  .rf_wr       (rf_wr),
  .rf_lane_lo  (rf_lane_lo),
  .rf_lane_hi  (rf_lane_hi)
);

// File: tb/slave_cycle_decoder_test.sv
module slave_cycle_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] bus_addr;
  logic        bus_mio, bus_s0_n, bus_s1_n, bus_below16m, bus_bhe_n;
  logic        bus_adl_n, bus_cmd_n, bus_setup_n;
  logic        card_sel_n, card_ds16_n, card_rdy;
  logic [2:0]  rf_addr;
  logic        rf_rd, rf_wr, rf_lane_lo, rf_lane_hi;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  slave_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_mio(bus_mio),
    .bus_s0_n(bus_s0_n), .bus_s1_n(bus_s1_n), .bus_below16m(bus_below16m),
    .bus_bhe_n(bus_bhe_n), .bus_adl_n(bus_adl_n), .bus_cmd_n(bus_cmd_n),
    .bus_setup_n(bus_setup_n), .card_sel_n(card_sel_n), .card_ds16_n(card_ds16_n),
    .card_rdy(card_rdy), .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_lane_lo(rf_lane_lo), .rf_lane_hi(rf_lane_hi)
  );

  // {mio, s0_n, s1_n, below16m, bhe_n, setup_n, addr, exp_sel, exp_lo, exp_hi, exp_ds16}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,24'h000302,4'b1111},  // IO write, both lanes
    {1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,24'h000303,4'b1011},  // IO read, high lane
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,24'hFF0301,4'b1001},  // upper bits ignored
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,24'h000308,4'b0000},  // past IO window
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,24'h000300,4'b0001},  // reserved 000
    {1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,24'h000300,4'b0001},  // reserved 011
    {1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,24'h0C8010,4'b1101},  // mem read, low lane
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,24'h0CBFFF,4'b1011},  // mem write, top byte
    {1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,24'h0C8000,4'b0000},  // above 16 MB
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,24'h0CC000,4'b0000},  // past memory window
    {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,24'h0C8000,4'b0001},  // reserved 100
    {1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,24'h0C8000,4'b0001},  // reserved 111
    {1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,24'h0C8000,4'b0001},  // setup access
    {1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,24'h000300,4'b0000}   // memory at IO address
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic latch_phase(input logic mio, s0, s1, b16, bhe, setup, input logic [23:0] a);
    @(negedge clk);
    bus_mio = mio; bus_s0_n = s0; bus_s1_n = s1; bus_below16m = b16;
    bus_bhe_n = bhe; bus_setup_n = setup; bus_addr = a; bus_adl_n = 1'b0;
    @(negedge clk);
    bus_adl_n = 1'b1;
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_mio = 1'b0; bus_s0_n = 1'b1; bus_s1_n = 1'b1;
    bus_below16m = 1'b0; bus_bhe_n = 1'b1; bus_adl_n = 1'b1; bus_cmd_n = 1'b1;
    bus_setup_n = 1'b1;
    repeat (3) tick();

    // R11 reset state
    chk("R11 sel", card_sel_n, 1);
    chk("R11 rdy", card_rdy, 1);
    chk("R11 rd", rf_rd, 0);
    chk("R11 wr", rf_wr, 0);
    chk("R11 lanes", {rf_lane_hi, rf_lane_lo}, 0);

    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();

    // table: R1 R2 R3 R5 select, R6 size, R10 lanes
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      latch_phase(v[33], v[32], v[31], v[30], v[29], v[28], v[27:4]);
      chk($sformatf("R1/R2/R3/R5 select vec%0d", i), !card_sel_n, v[3]);
      chk($sformatf("R10 lanes vec%0d", i), {rf_lane_lo, rf_lane_hi}, v[2:1]);
      chk($sformatf("R6 size vec%0d", i), !card_ds16_n, v[0]);
    end
    @(negedge clk); bus_setup_n = 1'b1;

    // R4: held phase survives bus changes with the strobe high
    latch_phase(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h000302);
    chk("R4 sel before", card_sel_n, 0);
    chk("R4 addr before", rf_addr, 3'd2);
    @(negedge clk); bus_addr = 24'h000500;
    tick();
    chk("R4 sel held", card_sel_n, 0);
    chk("R4 addr held", rf_addr, 3'd2);
    chk("R6 size live", card_ds16_n, 1);

    // R4/R7/R9: command with no address strobe captures at its first edge
    @(negedge clk);
    bus_s0_n = 1'b1; bus_s1_n = 1'b0; bus_addr = 24'h000304; bus_cmd_n = 1'b0;
    tick();
    chk("R4 capture at cmd", card_sel_n, 0);
    chk("R4 addr at cmd", rf_addr, 3'd4);
    chk("R9 rd on", rf_rd, 1);
    chk("R7 wait 0", card_rdy, 0);
    @(negedge clk); bus_addr = 24'h000500;
    tick();
    chk("R7 wait 1", card_rdy, 0);
    chk("R4 hold in cmd", card_sel_n, 0);
    chk("R4 addr in cmd", rf_addr, 3'd4);
    tick();
    chk("R7 released", card_rdy, 1);
    chk("R8 no wr on read", rf_wr, 0);
    @(negedge clk); bus_cmd_n = 1'b1;
    #2;
    chk("R9 rd held past cmd", rf_rd, 1);
    tick();
    chk("R9 rd off", rf_rd, 0);

    // R7/R8: selected write, strobe once after the wait
    latch_phase(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h000301);
    @(negedge clk); bus_cmd_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk($sformatf("R8 wr clk%0d", i), rf_wr, (i == 2));
      chk($sformatf("R7 rdy clk%0d", i), card_rdy, (i >= 2));
    end
    @(negedge clk); bus_cmd_n = 1'b1;
    tick();
    chk("R8 wr idle", rf_wr, 0);

    // R7/R8: unselected write never waits or strobes
    latch_phase(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h000400);
    @(negedge clk); bus_cmd_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk($sformatf("R8 unsel wr clk%0d", i), rf_wr, 0);
      chk($sformatf("R7 unsel rdy clk%0d", i), card_rdy, 1);
    end
    @(negedge clk); bus_cmd_n = 1'b1;
    tick();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule